// File: doc/BRIEF.md
# Integrity Status Interrupt and Alarm Controller

This block sits behind a display integrity checker and turns its event pulses into software-visible state. A one-cycle "frame results ready" pulse and a vector of one-cycle per-region mismatch pulses are captured in a status register. Software clears the captured flags by writing ones. An error summary bit is derived from the region flags and cannot be written.

Two mask bits gate the frame-ready and error conditions onto a single level-sensitive interrupt line. A sticky freeze bit locks both masks until reset.

An external alarm pin reports health by its toggle rate instead of its level. With the alarm enabled and the integrity check running, it toggles fast while no mismatch is pending and slowly while one is. Otherwise it rests low. The registers sit on a minimal single-cycle register bus. A write takes effect at the clock edge, and read data is combinational from the address.

Top module: `integ_alarm_ctrl`

## Requirements
- R1: A `frame_done` pulse sets the frame-ready flag, which reads as bit 0 of the status register (address 2) from the next cycle.
- R2: A pulse on `region_hit[i]` sets region flag i, read at status bit 2+i. When a set and a write-1 clear of the same flag fall in one cycle, the set wins.
- R3: Status bit 1 (error) reads 1 exactly when any region flag is set. Writing 1 to bit 1 has no effect, and the bit falls once every region flag has been cleared.
- R4: Writing the status register clears the frame-ready flag and each region flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R5: The interrupt control register (address 1) holds a frame-ready mask in bit 0 and an error mask in bit 1, both 1 after reset. `irq` equals (frame-ready AND NOT bit 0) OR (error AND NOT bit 1), and it holds high until the cause is cleared or masked.
- R6: Bit 2 of the interrupt control register is a freeze bit. Once it is set, mask writes are ignored, and only reset clears it. A write that sets freeze still updates the masks in that same write.
- R7: With control bits 0 (check enable) and 1 (alarm enable) of address 0 both set and the error bit set, `alarm` toggles with period 16 clocks: 8 high, 8 low.
- R8: With both control bits set and no error pending, `alarm` toggles with period 4 clocks: 2 high, 2 low.
- R9: `alarm` is held low while either control bit 0 or control bit 1 is clear.
- R10: After reset, control and status read 0, the interrupt control register reads 3, `irq` is 0 and `alarm` is 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, acts at the clock edge |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| frame_done | input | 1 | One-cycle frame results ready pulse |
| region_hit | input | 16 | One-cycle per-region mismatch pulses |
| irq | output | 1 | Level interrupt request |
| alarm | output | 1 | External alarm, rate-coded |

## Verification
Flags, masks and control bits change at the edge that samples a write or a pulse. `irq` and the read data therefore show the new value one cycle after the stimulus. The bench drives on the falling edge, waits one rising edge, and then compares at the next falling edge against a model that it updates after that same rising edge.

The alarm divider needs a few cycles to settle after its mode changes. The bench therefore waits 20 cycles before it measures. It then locks to a rising edge and counts the high and low samples against the expected half-period.

// File: rtl/integ_alarm_pkg.sv
package integ_alarm_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_INTCTL = 2'd1,
        REG_STATUS = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    localparam int CTRL_CHECK_BIT = 0;
    localparam int CTRL_ALARM_BIT = 1;
    localparam int INT_MFI_BIT    = 0;
    localparam int INT_MEI_BIT    = 1;
    localparam int INT_FRZ_BIT    = 2;
    localparam int ST_FUNC_BIT    = 0;
    localparam int ST_ERR_BIT     = 1;
    localparam int ST_REGION_LSB  = 2;
endpackage

// File: rtl/integ_status_bank.sv
module integ_status_bank #(
    parameter int NUM_REGIONS = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_func,
    input  logic [NUM_REGIONS-1:0] clr_regions,
    input  logic                   frame_done,
    input  logic [NUM_REGIONS-1:0] region_hit,
    output logic                   func_flag,
    output logic [NUM_REGIONS-1:0] region_flags,
    output logic                   err_flag
);
    typedef struct packed {
        logic                   func;
        logic [NUM_REGIONS-1:0] regions;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        // a new event beats a clear in the same cycle
        st_d.func    = (st_q.func & ~clr_func) | frame_done;
        st_d.regions = (st_q.regions & ~clr_regions) | region_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign func_flag    = st_q.func;
    assign region_flags = st_q.regions;
    assign err_flag     = |st_q.regions;

    p_func_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> func_flag);
    p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (region_hit != '0) |=> ((region_flags & $past(region_hit)) == $past(region_hit)));
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_regions & ~region_hit) != '0) |=>
            ((region_flags & $past(clr_regions & ~region_hit)) == '0));
endmodule

// File: rtl/integ_mask_unit.sv
module integ_mask_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic new_mfi,
    input  logic new_mei,
    input  logic new_frz,
    output logic mask_fi,
    output logic mask_ei,
    output logic frozen
);
    typedef struct packed {
        logic mfi;
        logic mei;
        logic frz;
    } mk_t;

    mk_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        if (wr_en) begin
            if (!mk_q.frz) begin
                mk_d.mfi = new_mfi;
                mk_d.mei = new_mei;
            end
            mk_d.frz = mk_q.frz | new_frz;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mk_q <= '{mfi: 1'b1, mei: 1'b1, frz: 1'b0};
        else        mk_q <= mk_d;
    end

    assign mask_fi = mk_q.mfi;
    assign mask_ei = mk_q.mei;
    assign frozen  = mk_q.frz;

    p_frozen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> (frozen && $stable(mask_fi) && $stable(mask_ei)));
endmodule

// File: rtl/integ_alarm_gen.sv
module integ_alarm_gen #(
    parameter int ERR_DIV = 16,
    parameter int OK_DIV  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic err,
    output logic alarm
);
    localparam int HALF_ERR = ERR_DIV / 2;
    localparam int HALF_OK  = OK_DIV / 2;
    localparam int HALF_MAX = (HALF_ERR > HALF_OK) ? HALF_ERR : HALF_OK;
    localparam int CNT_W    = $clog2(HALF_MAX + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pin;
    } al_t;

    al_t al_d, al_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last = err ? CNT_W'(HALF_ERR - 1) : CNT_W'(HALF_OK - 1);
        al_d = al_q;
        if (!run) begin
            al_d.cnt = '0;
            al_d.pin = 1'b0;
        end else if (al_q.cnt >= last) begin
            al_d.cnt = '0;
            al_d.pin = ~al_q.pin;
        end else begin
            al_d.cnt = al_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) al_q <= '0;
        else        al_q <= al_d;
    end

    assign alarm = al_q.pin;

    p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !alarm);
    p_fast_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !err && $past(run) && $past(!err) && $rose(alarm)) |=> alarm);
endmodule

// File: rtl/integ_alarm_ctrl.sv
module integ_alarm_ctrl
    import integ_alarm_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int DATA_W      = 32,
    parameter int ERR_DIV     = 16,
    parameter int OK_DIV      = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic                   frame_done,
    input  logic [NUM_REGIONS-1:0] region_hit,
    output logic                   irq,
    output logic                   alarm
);
    localparam int USED_W = ST_REGION_LSB + NUM_REGIONS;

    typedef struct packed {
        logic check_en;
        logic alarm_en;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                   wr_ctrl, wr_int, wr_st;
    logic                   func_flag, err_flag;
    logic [NUM_REGIONS-1:0] region_flags;
    logic                   mask_fi, mask_ei, frozen;

    assign wr_ctrl = bus_we && (bus_addr == REG_CTRL);
    assign wr_int  = bus_we && (bus_addr == REG_INTCTL);
    assign wr_st   = bus_we && (bus_addr == REG_STATUS);

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctrl) begin
            ctl_d.check_en = bus_wdata[CTRL_CHECK_BIT];
            ctl_d.alarm_en = bus_wdata[CTRL_ALARM_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    integ_status_bank #(.NUM_REGIONS(NUM_REGIONS)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_func     (wr_st && bus_wdata[ST_FUNC_BIT]),
        .clr_regions  (wr_st ? bus_wdata[USED_W-1:ST_REGION_LSB] : '0),
        .frame_done   (frame_done),
        .region_hit   (region_hit),
        .func_flag    (func_flag),
        .region_flags (region_flags),
        .err_flag     (err_flag)
    );

    integ_mask_unit u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_int),
        .new_mfi (bus_wdata[INT_MFI_BIT]),
        .new_mei (bus_wdata[INT_MEI_BIT]),
        .new_frz (bus_wdata[INT_FRZ_BIT]),
        .mask_fi (mask_fi),
        .mask_ei (mask_ei),
        .frozen  (frozen)
    );

    integ_alarm_gen #(.ERR_DIV(ERR_DIV), .OK_DIV(OK_DIV)) u_alarm (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctl_q.check_en && ctl_q.alarm_en),
        .err   (err_flag),
        .alarm (alarm)
    );

    assign irq = (func_flag && !mask_fi) || (err_flag && !mask_ei);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL: begin
                bus_rdata[CTRL_CHECK_BIT] = ctl_q.check_en;
                bus_rdata[CTRL_ALARM_BIT] = ctl_q.alarm_en;
            end
            REG_INTCTL: begin
                bus_rdata[INT_MFI_BIT] = mask_fi;
                bus_rdata[INT_MEI_BIT] = mask_ei;
                bus_rdata[INT_FRZ_BIT] = frozen;
            end
            REG_STATUS: begin
                bus_rdata[ST_FUNC_BIT]                   = func_flag;
                bus_rdata[ST_ERR_BIT]                    = err_flag;
                bus_rdata[USED_W-1:ST_REGION_LSB]        = region_flags;
            end
            default: bus_rdata = '0;
        endcase
    end

    generate
        if (DATA_W > USED_W) begin : g_spare
            logic unused_wdata;
            assign unused_wdata = ^bus_wdata[DATA_W-1:USED_W];
        end
    endgenerate

    p_err_no_direct_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && wr_st && ((bus_wdata[USED_W-1:ST_REGION_LSB] & region_flags) == '0))
            |=> err_flag);
    p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_we) |=> irq);
endmodule

// File: tb/test_integ_alarm_ctrl.sv
module test_integ_alarm_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        frame_done = 1'b0;
    logic [NR-1:0] region_hit = '0;
    logic        irq, alarm;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model
    bit          m_fi, m_mfi, m_mei, m_frz;
    bit [NR-1:0] m_flags;
    bit [1:0]    m_ctl;

    always #(CLK_PERIOD/2) clk = ~clk;

    integ_alarm_ctrl i_integ_alarm_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_done(frame_done),
        .region_hit(region_hit), .irq(irq), .alarm(alarm)
    );

    function automatic bit exp_irq();
        return (m_fi && !m_mfi) || ((|m_flags) && !m_mei);
    endfunction

    function automatic logic [31:0] exp_reg(input logic [1:0] a);
        case (a)
            2'd0: return {30'd0, m_ctl};
            2'd1: return {29'd0, m_frz, m_mei, m_mfi};
            2'd2: return {14'd0, m_flags, |m_flags, m_fi};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus/event cycle; model updates after the sampling edge
    task automatic cyc(input bit we, input logic [1:0] a, input logic [31:0] d,
                       input logic [NR-1:0] rp, input bit fd);
        bus_we = we; bus_addr = a; bus_wdata = d; region_hit = rp; frame_done = fd;
        @(posedge clk);
        if (we && a == 2'd2) begin
            m_fi    = (m_fi & ~d[0]) | fd;
            m_flags = (m_flags & ~d[17:2]) | rp;
        end else begin
            m_fi    = m_fi | fd;
            m_flags = m_flags | rp;
        end
        if (we && a == 2'd1) begin
            if (!m_frz) begin m_mfi = d[0]; m_mei = d[1]; end
            m_frz = m_frz | d[2];
        end
        if (we && a == 2'd0) m_ctl = d[1:0];
        @(negedge clk);
        bus_we = 1'b0; region_hit = '0; frame_done = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] a);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp_reg(a));
    endtask

    task automatic measure(input string req, input int half);
        int hi = 0, lo = 0, guard = 0;
        repeat (20) @(negedge clk);
        while (alarm !== 1'b0 && guard < 100) begin @(negedge clk); guard++; end
        while (alarm !== 1'b1 && guard < 100) begin @(negedge clk); guard++; end
        while (alarm === 1'b1 && guard < 100) begin hi++; @(negedge clk); guard++; end
        while (alarm === 1'b0 && guard < 100) begin lo++; @(negedge clk); guard++; end
        check({req, " high"}, hi, half);
        check({req, " low"}, lo, half);
    endtask

    task automatic idle_check(input string req);
        int seen = 0;
        repeat (40) begin @(negedge clk); if (alarm !== 1'b0) seen++; end
        check(req, seen, 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        m_fi = 0; m_mfi = 1; m_mei = 1; m_frz = 0; m_flags = '0; m_ctl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd_check("R10 ctrl", 2'd0);
        rd_check("R10 intctl", 2'd1);
        rd_check("R10 status", 2'd2);
        rd_check("R10 addr3", 2'd3);
        check("R10 irq", irq, 0);
        check("R10 alarm", alarm, 0);

        // R1 frame-ready flag, R5 unmask it
        cyc(1, 2'd1, 32'h2, '0, 1);
        rd_check("R1 func set", 2'd2);
        check("R5 irq func", irq, exp_irq());
        // R2 set beats clear
        cyc(0, 2'd0, 0, 16'h0010, 0);
        cyc(1, 2'd2, 32'h0010 << 2, 16'h0010, 0);
        rd_check("R2 set wins", 2'd2);
        // R3 writing error bit only leaves it
        cyc(1, 2'd2, 32'h2, '0, 0);
        rd_check("R3 err write ignored", 2'd2);
        // R4 partial clear then full clear
        cyc(0, 2'd0, 0, 16'h8001, 0);
        cyc(1, 2'd2, 32'h0001 << 2, '0, 0);
        rd_check("R4 partial clear", 2'd2);
        cyc(1, 2'd2, 32'hFFFF_FFFF, '0, 0);
        rd_check("R3 err falls", 2'd2);
        check("R5 irq cleared", irq, exp_irq());

        // random phase: R1 R2 R4 R5 R6
        for (int i = 0; i < 600; i++) begin
            bit we; logic [1:0] a; logic [31:0] d; logic [NR-1:0] rp; bit fd;
            we = $urandom_range(1, 0);
            a  = 2'($urandom_range(3, 0));
            d  = $urandom;
            if ($urandom_range(31, 0) != 0) d[2] = 1'b0;
            rp = NR'($urandom & $urandom & $urandom);
            fd = ($urandom_range(3, 0) == 0);
            cyc(we, a, d, rp, fd);
            check("R5 irq random", irq, exp_irq());
            rd_check("R4 status random", 2'd2);
            rd_check("R6 intctl random", 2'd1);
        end

        // R6 directed freeze
        cyc(1, 2'd1, 32'h4, '0, 0);
        cyc(1, 2'd1, 32'h3, '0, 0);
        rd_check("R6 frozen masks", 2'd1);
        cyc(1, 2'd1, 32'h0, '0, 0);
        rd_check("R6 freeze sticky", 2'd1);

        // alarm
        cyc(1, 2'd2, 32'hFFFF_FFFF, '0, 0);
        cyc(1, 2'd0, 32'h3, '0, 0);
        measure("R8 fast alarm", 2);
        cyc(0, 2'd0, 0, 16'h0004, 0);
        measure("R7 slow alarm", 8);
        cyc(1, 2'd0, 32'h1, '0, 0);
        idle_check("R9 alarm disabled");
        cyc(1, 2'd0, 32'h2, '0, 0);
        idle_check("R9 check disabled");
        cyc(1, 2'd2, 32'hFFFF_FFFF, '0, 0);
        cyc(1, 2'd0, 32'h3, '0, 0);
        measure("R8 fast after clear", 2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule